// File: doc/BRIEF.md
# LFSR-Coded Coarse Divisor Codec

This block translates a clock-divider setting between its plain integer form and the packed word a divider hardware expects. The integer divisor is split into a coarse part (divisor divided by four) and a 2-bit fine part (divisor modulo four). The divider counts its coarse part with an 11-bit Galois shift register rather than a binary counter, so the coarse field of the packed word is a register state, not a number. This codec finds that state by walking the register sequence, one step per clock.

Encoding takes an integer divisor and returns the packed word: state in bits [12:2], fine part in bits [1:0]. Decoding takes a packed word and recovers the integer divisor by counting steps until the walking state equals the coarse field. Coarse value 2 is the smallest legal value. It is special: it maps to the all-zero field with no walking. Divisors whose coarse part is below 2 or above 2049 are refused with an error flag and an all-zero word.

The controller has three states. `ST_IDLE` waits for `start`. It goes to `ST_DONE` directly for a zero-code or out-of-range request, and to `ST_WALK` otherwise. `ST_WALK` advances the register and the step counter each clock. It leaves to `ST_DONE` on a target hit, or when the whole period is used up. `ST_DONE` holds for one cycle and returns to `ST_IDLE`.

Top module: `nco_div_codec`

## Requirements
- R1: After reset `busy`, `done` and `err` are low, and `code_out` and `div_out` are zero.
- R2: One step shifts the 11-bit state right by one. If the bit shifted out was 1, the state is also XORed with 0x500. Starting from 0x7FF, the state reached after k steps (k = 1..2047) is the coarse field for index 2048 − k, where index = coarse − 2.
- R3: An encoded word carries the coarse state in bits [12:2] and the divisor modulo 4 in bits [1:0].
- R4: An encode with coarse value 2 yields coarse field 0, with no stepping.
- R5: An encode with coarse value below 2 or at least 2050 raises `err` with `code_out` equal to zero.
- R6: Decoding a word whose coarse field is a nonzero state returns (2048 − k + 2)·4 + fine, where k is the number of steps from 0x7FF to that state.
- R7: Decoding a word with coarse field 0 returns 8 + fine.
- R8: `done` is high for exactly one cycle. It rises k clock edges after the edge that accepts `start`, where k is the step count (0 for the zero code and for refused requests).
- R9: A `start` pulse while `busy` is high is ignored. The running conversion finishes with its own result and timing, and the output it does not target keeps its value.
- R10: For every legal divisor, decoding the encoded word returns the original divisor.
- R11: `busy` is high from the accepting edge through the `done` cycle and low in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a conversion (accepted only in `ST_IDLE`) |
| op | input | 1 | 0 = encode `div_in`, 1 = decode `code_in` |
| div_in | input | 14 | Integer divisor to encode |
| code_in | input | 13 | Packed word to decode |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request refused or state not found |
| code_out | output | 13 | Encoded word, valid with `done` after an encode |
| div_out | output | 14 | Decoded divisor, valid with `done` after a decode |

## Verification
A wrong step rule or a bad seed shows up at the first `done` after any walking encode, as a coarse field that differs from the reference sequence. A wrong step counter shows in the same cycle as a latency off by one or more edges, and in a decode as a divisor shifted by the same amount. A corrupted range check or zero-code path is visible at once, because those requests complete on the accepting edge. A conversion that restarts while busy shows up as a changed result or latency at the end of the long walk.

// File: rtl/nco_div_pkg.sv
`timescale 1ns/1ps
package nco_div_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WALK,
        ST_DONE
    } walk_st_e;

    typedef enum logic {
        OP_ENC = 1'b0,
        OP_DEC = 1'b1
    } op_e;
endpackage

// File: rtl/lfsr_stepper.sv
`timescale 1ns/1ps
// One Galois step: shift right, fold the tap mask in when a 1 leaves.
module lfsr_stepper #(
    parameter int LFSR_W = 11,
    parameter int POLY   = 32'hA01
) (
    input  logic [LFSR_W-1:0] cur,
    output logic [LFSR_W-1:0] nxt
);
    localparam logic [LFSR_W-1:0] TAP = LFSR_W'(POLY >> 1);

    always_comb begin
        nxt = cur >> 1;
        if (cur[0]) begin
            nxt = (cur >> 1) ^ TAP;
        end
    end
endmodule

// File: rtl/div_splitter.sv
`timescale 1ns/1ps
// Splits an integer divisor into table index and fine part, with range test.
module div_splitter #(
    parameter int LFSR_W     = 11,
    parameter int FINE_W     = 2,
    parameter int COARSE_OFS = 2
) (
    input  logic [LFSR_W+FINE_W:0] div,
    output logic [LFSR_W-1:0]      idx,
    output logic [FINE_W-1:0]      fine,
    output logic                   bad
);
    localparam int DIV_W = LFSR_W + FINE_W + 1;
    localparam int CRS_W = DIV_W - FINE_W;
    localparam int HI    = COARSE_OFS + (1 << LFSR_W);

    logic [CRS_W-1:0] coarse;

    assign coarse = div[DIV_W-1:FINE_W];
    assign fine   = div[FINE_W-1:0];
    assign bad    = (int'(coarse) < COARSE_OFS) || (int'(coarse) >= HI);
    assign idx    = LFSR_W'(coarse - CRS_W'(COARSE_OFS));
endmodule

// File: rtl/nco_div_codec.sv
`timescale 1ns/1ps
module nco_div_codec
    import nco_div_pkg::*;
#(
    parameter int                 LFSR_W     = 11,
    parameter int                 POLY       = 32'hA01,
    parameter logic [LFSR_W-1:0]  SEED       = '1,
    parameter int                 FINE_W     = 2,
    parameter int                 COARSE_OFS = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          op,
    input  logic [LFSR_W+FINE_W:0]        div_in,
    input  logic [LFSR_W+FINE_W-1:0]      code_in,
    output logic                          busy,
    output logic                          done,
    output logic                          err,
    output logic [LFSR_W+FINE_W-1:0]      code_out,
    output logic [LFSR_W+FINE_W:0]        div_out
);
    localparam int CODE_W = LFSR_W + FINE_W;
    localparam int DIV_W  = CODE_W + 1;
    localparam int SPAN   = 1 << LFSR_W;
    localparam int PERIOD = SPAN - 1;

    walk_st_e            st, st_n;
    op_e                 op_q;
    logic [FINE_W-1:0]   fine_q;
    logic [LFSR_W-1:0]   goal_q;
    logic [LFSR_W-1:0]   lfsr_q;
    logic [LFSR_W-1:0]   cnt_q;
    logic [CODE_W-1:0]   code_q;
    logic [DIV_W-1:0]    divo_q;
    logic                err_q;

    logic [LFSR_W-1:0]   step_nxt;
    logic [LFSR_W-1:0]   cnt_inc;
    logic [LFSR_W-1:0]   sp_idx;
    logic [FINE_W-1:0]   sp_fine;
    logic                sp_bad;
    logic                enc_hit, dec_hit, exhaust, quick;
    logic [LFSR_W-1:0]   in_field;
    logic [DIV_W-1:0]    dec_div;

    lfsr_stepper #(.LFSR_W(LFSR_W), .POLY(POLY)) u_step (
        .cur (lfsr_q),
        .nxt (step_nxt)
    );

    div_splitter #(.LFSR_W(LFSR_W), .FINE_W(FINE_W), .COARSE_OFS(COARSE_OFS)) u_split (
        .div  (div_in),
        .idx  (sp_idx),
        .fine (sp_fine),
        .bad  (sp_bad)
    );

    assign in_field = code_in[CODE_W-1:FINE_W];
    assign cnt_inc  = cnt_q + 1'b1;
    assign enc_hit  = (op_q == OP_ENC) && (cnt_inc == goal_q);
    assign dec_hit  = (op_q == OP_DEC) && (step_nxt == goal_q);
    assign exhaust  = (cnt_inc == LFSR_W'(PERIOD));
    assign quick    = (op_e'(op) == OP_ENC) ? (sp_bad || (sp_idx == '0))
                                            : (in_field == '0);
    assign dec_div  = DIV_W'((SPAN - int'(cnt_inc) + COARSE_OFS) * (1 << FINE_W)
                             + int'(fine_q));

    // Next-state logic
    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE: if (start) st_n = quick ? ST_DONE : ST_WALK;
            ST_WALK: if (enc_hit || dec_hit || exhaust) st_n = ST_DONE;
            ST_DONE: st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // Datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_ENC;
            fine_q <= '0;
            goal_q <= '0;
            lfsr_q <= SEED;
            cnt_q  <= '0;
            code_q <= '0;
            divo_q <= '0;
            err_q  <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    op_q   <= op_e'(op);
                    lfsr_q <= SEED;
                    cnt_q  <= '0;
                    if (op_e'(op) == OP_ENC) begin
                        fine_q <= sp_fine;
                        goal_q <= LFSR_W'(SPAN - int'(sp_idx));
                        err_q  <= sp_bad;
                        code_q <= sp_bad ? '0 : {{LFSR_W{1'b0}}, sp_fine};
                    end else begin
                        fine_q <= code_in[FINE_W-1:0];
                        goal_q <= in_field;
                        err_q  <= 1'b0;
                        divo_q <= DIV_W'(COARSE_OFS * (1 << FINE_W)
                                         + int'(code_in[FINE_W-1:0]));
                    end
                end
                ST_WALK: begin
                    lfsr_q <= step_nxt;
                    cnt_q  <= cnt_inc;
                    if (enc_hit)      code_q <= {step_nxt, fine_q};
                    else if (dec_hit) divo_q <= dec_div;
                    else if (exhaust) err_q  <= 1'b1;
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    assign busy     = (st != ST_IDLE);
    assign done     = (st == ST_DONE);
    assign err      = err_q;
    assign code_out = code_q;
    assign div_out  = divo_q;

    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the step counter never runs past one full period
    p_walk_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WALK) |-> (cnt_q < LFSR_W'(PERIOD)));

    // R2: a walking register never falls into the all-zero lockup state
    p_lfsr_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WALK) |-> (lfsr_q != '0));

    // R9: a start while busy leaves the captured request untouched
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(op_q) && $stable(goal_q) && $stable(fine_q)));

    // R5: a refused encode presents an all-zero word
    p_bad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err && (op_q == OP_ENC)) |-> (code_out == '0));

    // R6: a successful decode never returns less than the smallest legal divisor
    p_dec_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && (op_q == OP_DEC)) |-> (int'(div_out) >= COARSE_OFS * (1 << FINE_W)));
endmodule

// File: tb/nco_div_codec_tb.sv
`timescale 1ns/1ps
module nco_div_codec_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op = 1'b0;
    logic [13:0] div_in = '0;
    logic [12:0] code_in = '0;
    logic        busy, done, err;
    logic [12:0] code_out;
    logic [13:0] div_out;

    int total = 0;
    int bad = 0;
    int fwd [2048];

    always #(CLK_PERIOD/2) clk = ~clk;

    nco_div_codec u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .div_in(div_in), .code_in(code_in), .busy(busy), .done(done),
        .err(err), .code_out(code_out), .div_out(div_out)
    );

    function automatic int mstep(input int s);
        if (s & 1) return (s >> 1) ^ 32'h500;
        return s >> 1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input bit o, input int din, input int win, output int lat);
        @(negedge clk);
        op = o; div_in = 14'(din); code_in = 13'(win); start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        lat = 0;
        while (!done && lat < 5000) begin
            @(posedge clk); #1;
            lat++;
        end
    endtask

    task automatic settle();
        @(posedge clk); #1;
        check("R11 idle busy", int'(busy), 0);
    endtask

    task automatic t_reset();
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 err", int'(err), 0);
        check("R1 code_out", int'(code_out), 0);
        check("R1 div_out", int'(div_out), 0);
    endtask

    task automatic t_zero_code();
        int lat;
        run(1'b0, 9, 0, lat);
        check("R4 code", int'(code_out), 1);
        check("R4 err", int'(err), 0);
        check("R8 zero-code latency", lat, 0);
        settle();
        run(1'b1, 0, 2, lat);
        check("R7 div", int'(div_out), 10);
        check("R7 err", int'(err), 0);
        check("R8 decode zero latency", lat, 0);
        settle();
    endtask

    task automatic t_range();
        int lat;
        run(1'b0, 7, 0, lat);
        check("R5 low err", int'(err), 1);
        check("R5 low code", int'(code_out), 0);
        check("R8 refuse latency", lat, 0);
        settle();
        run(1'b0, 8200, 0, lat);
        check("R5 high err", int'(err), 1);
        check("R5 high code", int'(code_out), 0);
        settle();
        run(1'b0, 0, 0, lat);
        check("R5 zero err", int'(err), 1);
        settle();
        run(1'b0, 8199, 0, lat);
        check("R2 top coarse code", int'(code_out), (fwd[2047] << 2) | 3);
        check("R5 top coarse err", int'(err), 0);
        check("R8 one-step latency", lat, 1);
        settle();
    endtask

    task automatic t_fine();
        int lat;
        for (int f = 0; f < 4; f++) begin
            run(1'b0, 40 + f, 0, lat);
            check("R3 fine bits", int'(code_out) & 3, f);
            check("R3 coarse bits", int'(code_out) >> 2, fwd[8]);
            check("R8 latency", lat, 2048 - 8);
            settle();
        end
    endtask

    task automatic t_busy();
        int lat;
        int div_before;
        div_before = int'(div_out);
        @(negedge clk);
        op = 1'b0; div_in = 14'd12; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        lat = 0;
        repeat (5) begin @(posedge clk); #1; lat++; end
        check("R11 busy mid-walk", int'(busy), 1);
        @(negedge clk);
        op = 1'b1; code_in = 13'd0; div_in = 14'd9; start = 1'b1;
        @(posedge clk); #1;
        lat++;
        start = 1'b0;
        while (!done && lat < 5000) begin
            @(posedge clk); #1;
            lat++;
        end
        check("R9 result kept", int'(code_out), fwd[1] << 2);
        check("R9 latency kept", lat, 2047);
        check("R9 div_out untouched", int'(div_out), div_before);
        check("R11 busy in done", int'(busy), 1);
        settle();
    endtask

    task automatic t_roundtrip();
        int lat, idx, d, w;
        for (int c = 2; c <= 2049; c += 127) begin
            for (int pass = 0; pass < 2; pass++) begin
                int cc;
                cc = (pass == 0) ? c : 2049 - (c % 61);
                idx = cc - 2;
                d = cc * 4 + (cc % 4);
                run(1'b0, d, 0, lat);
                w = int'(code_out);
                check("R2 encode", w, (fwd[idx] << 2) | (cc % 4));
                settle();
                run(1'b1, 0, w, lat);
                check("R10 round trip", int'(div_out), d);
                check("R6 decode err", int'(err), 0);
                check("R8 decode latency", lat, (idx == 0) ? 0 : 2048 - idx);
                settle();
            end
        end
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
        finish_up();
    end

    initial begin
        int s;
        s = 32'h7FF;
        for (int i = 2047; i > 0; i--) begin
            s = mstep(s);
            fwd[i] = s;
        end
        fwd[0] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_zero_code();
        t_range();
        t_fine();
        t_busy();
        t_roundtrip();
        finish_up();
    end
endmodule